// File: doc/BRIEF.md
# Station-Address PROM Signature Hunter

This block finds a fixed 8-byte marker in the byte stream of a station-address PROM whose read pointer sits at an unknown position after power-up. After a `start` pulse it requests PROM bytes one at a time. It follows the marker with a match index and stops requesting bytes on the very byte that completes the marker. The next byte the PROM will return is then the first byte of the station address, which a neighbouring block reads. If the marker does not show up within a bounded number of reads, the block reports that no PROM is present.

The marker is built from a 32-bit parameter `SIG_WORD`, which appears twice, and each copy is split into bytes least-significant byte first. The read budget is `PROBE_LEN + 7` bytes. This budget covers every possible starting offset within `PROBE_LEN` positions, plus the length of the marker less one.

The PROM side is a valid/ready pair. The PROM model drives `prom_byte` and holds it with `prom_vld`. The block raises `prom_req` as its ready, and a byte is consumed only in a cycle where both are high. The PROM may hold `prom_vld` low for any number of cycles, and the block simply waits. When `prom_req` is low, a presented byte stays where it is and is not consumed.

Top module: `sig_hunt`

## Requirements
- R1: Marker byte k (k = 0..7) equals bits [8*(k mod 4)+7 : 8*(k mod 4)] of `SIG_WORD`. The block reports found only for that byte order. A stream that holds each 32-bit copy in the opposite byte order ends in fail.
- R2: A byte is consumed only in a cycle where `prom_vld` and `prom_req` are both high. `prom_req` is high only while a search runs. While it is low, bytes offered with `prom_vld` high are not consumed and the outputs do not change. Stall cycles with `prom_vld` low do not change the result.
- R3: When a consumed byte equals the marker byte at the current match index, the index advances by one.
- R4: When a consumed byte does not equal the expected marker byte, the index becomes 1 if the byte equals marker byte 0, and 0 otherwise.
- R5: When the index reaches 8, `found` rises and `prom_req` falls in the next cycle. The consumed byte count ends exactly on the last marker byte.
- R6: If `PROBE_LEN + 7` bytes have been consumed without a full match, `fail` rises and no further byte is consumed.
- R7: When the final permitted byte also completes the marker, the result is found, not fail.
- R8: `start` clears the match index and the read counter at any time, including during a search. `prom_req` is low in the `start` cycle.
- R9: `done` is high for exactly one cycle, the cycle after the finishing byte is consumed. Exactly one of `found` and `fail` rises together with `done`. That flag holds until the cycle after the next `start`, which clears both flags.
- R10: After reset, `prom_req`, `done`, `found` and `fail` are all low, and no byte is consumed until `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart a search |
| prom_byte | input | 8 | Byte returned by the PROM |
| prom_vld | input | 1 | `prom_byte` is valid |
| prom_req | output | 1 | Ready: the block will consume a valid byte this cycle |
| done | output | 1 | One-cycle pulse when a search ends |
| found | output | 1 | Marker was found, held until the next start |
| fail | output | 1 | Read budget exhausted, held until the next start |

## Verification
Two events can land on the same consumed byte: the byte that completes the marker, and the byte that uses up the last unit of the read budget. The bench places the marker so that its final byte is exactly read number `PROBE_LEN + 7`. It then checks that the result is found with that read count, not fail. A second placement, shifted one byte later, must end in fail at the same count.

A restart that arrives while a byte is being offered is a second such pair. The bench judges it by the read pointer and by how long the restarted search takes to finish.

// File: rtl/sig_hunt_pkg.sv
package sig_hunt_pkg;

  typedef enum logic [0:0] {
    HUNT_IDLE = 1'b0,
    HUNT_SCAN = 1'b1
  } hunt_state_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/sig_hunt_match.sv
module sig_hunt_match #(
  parameter logic [31:0] SIG_WORD   = 32'hAA5500FF,
  parameter int          WORD_BYTES = 4,
  parameter int          WORD_REPS  = 2,
  localparam int         SIG_LEN    = WORD_BYTES * WORD_REPS,
  localparam int         IDX_W      = $clog2(SIG_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic [7:0]       byte_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [7:0]       sig_tbl [SIG_LEN];
  logic [7:0]       exp_byte;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nxt;

  // marker bytes: each word copy laid out low byte first
  for (genvar g = 0; g < SIG_LEN; g++) begin : g_sig
    assign sig_tbl[g] = SIG_WORD[8*(g % WORD_BYTES) +: 8];
  end

  always_comb begin
    exp_byte = '0;
    for (int k = 0; k < SIG_LEN; k++) begin
      if (idx_q == IDX_W'(k)) exp_byte = sig_tbl[k];
    end
  end

  always_comb begin
    if (byte_i == exp_byte)        idx_nxt = idx_q + IDX_W'(1);
    else if (byte_i == sig_tbl[0]) idx_nxt = IDX_W'(1);
    else                           idx_nxt = '0;
  end

  assign hit_o = take_i && (idx_nxt == IDX_W'(SIG_LEN));
  assign idx_o = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (take_i) idx_q <= idx_nxt;
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !clr_i) |=> $stable(idx_q)); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !clr_i) |=> ((idx_q == $past(idx_q) + IDX_W'(1)) || (idx_q <= IDX_W'(1)))); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(SIG_LEN)); // R4
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (idx_q == '0)); // R8

endmodule

// File: rtl/sig_hunt_ctrl.sv
module sig_hunt_ctrl
  import sig_hunt_pkg::*;
#(
  parameter int  LIMIT = 71,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic take_i,
  input  logic hit_i,
  output logic scan_o,
  output logic done_o,
  output logic found_o,
  output logic fail_o
);

  hunt_state_t      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_read;

  assign last_read = (cnt_q == CNT_W'(LIMIT - 1));
  assign scan_o    = (state_q == HUNT_SCAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= HUNT_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      found_o <= 1'b0;
      fail_o  <= 1'b0;
    end else if (start_i) begin
      state_q <= HUNT_SCAN;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      found_o <= 1'b0;
      fail_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (scan_o && take_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
        // a completed marker outranks an exhausted budget
        if (hit_i) begin
          found_o <= 1'b1;
          done_o  <= 1'b1;
          state_q <= HUNT_IDLE;
        end else if (last_read) begin
          fail_o  <= 1'b1;
          done_o  <= 1'b1;
          state_q <= HUNT_IDLE;
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    scan_o |-> (cnt_q < CNT_W'(LIMIT))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(found_o && fail_o)); // R9
  AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(found_o) || $rose(fail_o)) |-> done_o); // R9
  AST_FOUND_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> !scan_o); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!found_o && !fail_o && cnt_q == '0)); // R8

endmodule

// File: rtl/sig_hunt.sv
module sig_hunt
  import sig_hunt_pkg::*;
#(
  parameter logic [31:0] SIG_WORD  = 32'hAA5500FF,
  parameter int          PROBE_LEN = 64,
  localparam int         SIG_LEN   = 8,
  localparam int         LIMIT     = PROBE_LEN + SIG_LEN - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] prom_byte,
  input  logic              prom_vld,
  output logic              prom_req,
  output logic              done,
  output logic              found,
  output logic              fail
);

  localparam int IDX_W = $clog2(SIG_LEN + 1);

  logic             scan;
  logic             take;
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign prom_req = scan && !start;
  assign take     = prom_vld && prom_req;

  sig_hunt_match #(
    .SIG_WORD   (SIG_WORD),
    .WORD_BYTES (4),
    .WORD_REPS  (2)
  ) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start),
    .take_i (take),
    .byte_i (prom_byte),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  sig_hunt_ctrl #(
    .LIMIT (LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .take_i  (take),
    .hit_i   (hit),
    .scan_o  (scan),
    .done_o  (done),
    .found_o (found),
    .fail_o  (fail)
  );

  AST_NO_REQ_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !prom_req); // R8
  AST_FULL_AT_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> (idx == IDX_W'(SIG_LEN))); // R5

endmodule

// File: tb/sig_hunt_tb.sv
module sig_hunt_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SIG = 32'hAA5500FF;
  localparam int PROBE = 16;
  localparam int LIM = PROBE + 7;   // 23
  localparam int ROM_N = 64;

  // {pos (255 = none), fill, expect found, expect reads}
  localparam logic [31:0] VEC [7] = '{
    {8'd0,   8'h11, 8'd1, 8'd8},   // R3 marker at offset 0
    {8'd5,   8'h11, 8'd1, 8'd13},  // R3 offset marker
    {8'd15,  8'h11, 8'd1, 8'd23},  // R7 completes on last read
    {8'd16,  8'h11, 8'd0, 8'd23},  // R6 one byte too late
    {8'd255, 8'hFF, 8'd0, 8'd23},  // R4 stream of first byte
    {8'd3,   8'hFF, 8'd1, 8'd11},  // R4 restart to index 1
    {8'd255, 8'h00, 8'd0, 8'd23}   // R6 no marker
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       prom_vld = 1'b0;
  logic [7:0] prom_byte;
  logic       prom_req, done, found, fail;
  logic       rewind = 1'b0;
  logic [7:0] rom [ROM_N];
  int         ptr = 0;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign prom_byte = rom[ptr % ROM_N];

  always @(posedge clk) begin
    if (rewind) ptr <= 0;
    else if (prom_vld && prom_req) ptr <= ptr + 1;
  end

  sig_hunt #(.SIG_WORD(SIG), .PROBE_LEN(PROBE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prom_byte(prom_byte),
    .prom_vld(prom_vld), .prom_req(prom_req), .done(done),
    .found(found), .fail(fail)
  );

  function automatic logic [7:0] sig_b(int k);
    return SIG[8*(k % 4) +: 8];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_rom(logic [7:0] fill, int pos);
    for (int i = 0; i < ROM_N; i++) rom[i] = fill;
    if (pos != 255) begin
      for (int k = 0; k < 8; k++) rom[pos + k] = sig_b(k);
      rom[pos + 8] = 8'h5A;
    end
  endtask

  task automatic launch(bit rew);
    @(negedge clk);
    start = 1'b1; rewind = rew; prom_vld = 1'b1;
    @(negedge clk);
    start = 1'b0; rewind = 1'b0; prom_vld = 1'b0;
  endtask

  task automatic wait_done(int mode, output bit seen);
    int cyc = 0;
    seen = 1'b0;
    while (!seen && cyc < 500) begin
      prom_vld = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      @(negedge clk);
      cyc++;
      if (done) seen = 1'b1;
    end
    prom_vld = 1'b0;
  endtask

  task automatic judge(string req, bit exp_found, int exp_reads);
    bit seen;
    bit f_found;
    wait_done(0, seen);
    f_found = found;
    check(seen, req, "done seen", seen, 1);
    check(found == exp_found && fail == !exp_found, req, "found", found, exp_found);
    check(ptr == exp_reads, req, "reads", ptr, exp_reads);
    @(negedge clk);
    check(!done, "R9", "done width", done, 0);
    check(found == f_found, "R9", "flag held", found, f_found);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    load_rom(8'h11, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    prom_vld = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state, R2 no consumption while idle
    check(!prom_req && !done && !found && !fail, "R10", "outputs after reset",
          {prom_req, done, found, fail}, 0);
    check(ptr == 0, "R2", "idle consumption", ptr, 0);
    prom_vld = 1'b0;

    // table walk, alternating stall patterns
    for (int i = 0; i < 7; i++) begin
      bit seen;
      int pos, exp_f, exp_r;
      pos   = int'(VEC[i][31:24]);
      exp_f = int'(VEC[i][15:8]);
      exp_r = int'(VEC[i][7:0]);
      load_rom(VEC[i][23:16], pos);
      launch(1'b1);
      check(!found && !fail, "R8", "flags cleared by start", found, 0);
      wait_done(i % 2, seen);
      check(seen, "R9", "done seen", seen, 1);
      check(found == exp_f[0], "R3", "table found", found, exp_f);
      check(fail == !exp_f[0], "R6", "table fail", fail, !exp_f[0]);
      check(ptr == exp_r, "R5", "table reads", ptr, exp_r);
      if (exp_f != 0)
        check(prom_byte == 8'h5A, "R5", "next byte is address", prom_byte, 8'h5A);
      @(negedge clk);
      check(!done, "R9", "done one cycle", done, 0);
      // R2: offered bytes are ignored once finished
      prom_vld = 1'b1;
      repeat (4) @(negedge clk);
      prom_vld = 1'b0;
      check(ptr == exp_r && !prom_req, "R2", "no read after end", ptr, exp_r);
      check(found == exp_f[0], "R9", "flag holds", found, exp_f);
    end

    // R4: marker broken at index 7 by the first marker byte
    load_rom(8'h11, 255);
    for (int k = 0; k < 7; k++) rom[k] = sig_b(k);
    for (int k = 0; k < 8; k++) rom[7 + k] = sig_b(k);
    rom[15] = 8'h5A;
    launch(1'b1);
    judge("R4", 1'b1, 15);

    // R3/R4: marker broken at index 7 by an unrelated byte
    load_rom(8'h11, 255);
    for (int k = 0; k < 7; k++) rom[k] = sig_b(k);
    for (int k = 0; k < 8; k++) rom[8 + k] = sig_b(k);
    launch(1'b1);
    judge("R3", 1'b1, 16);

    // R1: each word copy in the opposite byte order never matches
    load_rom(8'h11, 255);
    for (int k = 0; k < 8; k++) rom[k] = sig_b((k / 4) * 4 + 3 - (k % 4));
    launch(1'b1);
    judge("R1", 1'b0, LIM);

    // R8: restart clears the match index
    load_rom(8'h11, 255);
    for (int k = 0; k < 4; k++) rom[k] = sig_b(k);
    for (int k = 0; k < 8; k++) rom[4 + k] = sig_b(k);
    launch(1'b1);
    prom_vld = 1'b1;
    repeat (4) @(negedge clk);
    prom_vld = 1'b0;
    check(ptr == 4 && !done, "R8", "partial reads", ptr, 4);
    launch(1'b0);
    judge("R8", 1'b1, 12);

    // R8: restart clears the read counter
    load_rom(8'h11, 255);
    launch(1'b1);
    prom_vld = 1'b1;
    repeat (10) @(negedge clk);
    prom_vld = 1'b0;
    launch(1'b0);
    judge("R8", 1'b0, 10 + LIM);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule